// File: doc/BRIEF.md
# Serial LED On/Off Register with Status Readback

This block is the digital core of a multi-channel LED sink driver. A host shifts one on/off bit per channel into a shift register over a slow serial clock. A latch strobe copies the shifted word into the enable latch that drives the channels. On the same strobe, the shift register is reloaded with a captured fault word, which the host then reads out of the serial output while it shifts in the next frame. The serial output is the top bit of the shift register, so several devices can be chained.

A blanking input forces every channel off. It also decides when faults are captured. While blanking is low, the status latch follows the live fault word. When blanking rises, the latch freezes at its last value. A channel reports a fault when it is enabled, has been enabled long enough to settle, and its open-LED flag is set. An over-temperature flag turns every status bit to one.

The serial clock, the latch strobe, the blanking pin and the serial data are sampled into the system clock through synchronizer chains. The fault inputs are treated as signals that are already synchronous to the system clock.

Top module: `led_onoff_core`

## Requirements
- R1: On each rising edge of `ser_clk_i`, the sampled `ser_data_i` enters shift-register bit 0 and every other bit moves up one place toward bit CH-1. A word presented most significant bit first therefore ends up with its bit k in register bit k.
- R2: `ser_data_o` always shows shift-register bit CH-1. It changes only after a serial clock edge or a latch strobe edge.
- R3: On a rising edge of `ser_latch_i`, the shift-register word is copied into the on/off latch. Bit n of the latch controls channel n.
- R4: On the same latch strobe edge, the shift register is loaded with the status word. Status bit n then appears on `ser_data_o` after CH-1-n further serial clocks.
- R5: While the synchronized blanking level is high, `chan_en_o` is all zeros. While it is low, `chan_en_o` equals the on/off latch.
- R6: While blanking is low, the status latch follows the live fault word. From the blanking rising edge until blanking goes low again, it holds that value, even if the fault inputs change.
- R7: Live status bit n is 1 exactly when channel n is enabled, is qualified, and `open_flag_i[n]` is 1. Otherwise it is 0, so a flag on a disabled channel reads back as 0.
- R8: While `hot_i` is 1 and blanking is low, the status latch becomes all ones.
- R9: A second latch strobe with no serial clock between the two strobes replaces the on/off latch with the status word. The block does not guard against this.
- R10: When a latch strobe edge and a serial clock edge fall in the same system clock, the latch transfer and status load happen first, and the shift is then applied to the loaded status word.
- R11: A synchronous reset clears the shift register, the on/off latch and the status latch. It also holds the blanking level high, so `chan_en_o` and `ser_data_o` are 0 after reset.
- R12: An open-LED flag is ignored until its channel has been enabled for at least MIN_ON consecutive clocks. An enable window shorter than MIN_ON clocks yields status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Serial shift clock; its rising edge shifts the register |
| ser_data_i | input | 1 | Serial data into bit 0 |
| ser_latch_i | input | 1 | Latch strobe; its rising edge commits on/off data and loads status |
| blank_i | input | 1 | High forces all channels off and freezes the status latch |
| open_flag_i | input | CH | Per-channel flag: output voltage is below the open-LED threshold |
| hot_i | input | 1 | Over-temperature flag |
| ser_data_o | output | 1 | Serial output from bit CH-1, for chaining |
| chan_en_o | output | CH | Per-channel sink enable |

## Verification
The shift path is tried with an asymmetric word that is read back through the serial output. This tells bit order and direction apart from a mirrored or off-by-one register. Fault capture is tried with flags on both enabled and disabled channels, with a flag change after the blanking edge, and with enable windows shorter and longer than MIN_ON. These separate qualification, masking and freezing. Back-to-back strobes, an over-temperature episode and coincident strobe and clock edges expose any mistake in the order of load and shift.

// File: rtl/led_core_pkg.sv
package led_core_pkg;
  localparam int unsigned DEF_CH     = 16;
  localparam int unsigned DEF_STAGES = 2;
  localparam int unsigned DEF_MIN_ON = 8;

  typedef struct packed {
    logic sclk_rise;
    logic lat_rise;
  } strobe_t;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= {W{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/onoff_shifter.sv
module onoff_shifter #(
  parameter int unsigned CH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          load_en,
  input  logic          sin,
  input  logic [CH-1:0] status,
  output logic [CH-1:0] shreg,
  output logic [CH-1:0] onoff
);
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      onoff <= '0;
    end else begin
      if (load_en) onoff <= shreg;
      unique case ({load_en, shift_en})
        2'b11:   shreg <= {status[CH-2:0], sin};
        2'b10:   shreg <= status;
        2'b01:   shreg <= {shreg[CH-2:0], sin};
        default: shreg <= shreg;
      endcase
    end
  end
endmodule

// File: rtl/fault_status.sv
module fault_status #(
  parameter int unsigned CH     = 16,
  parameter int unsigned MIN_ON = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          blank,
  input  logic [CH-1:0] chan_en,
  input  logic [CH-1:0] open_flag,
  input  logic          hot,
  output logic [CH-1:0] status
);
  localparam int unsigned CW = $clog2(MIN_ON + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_ON);

  logic [CH-1:0] qual;
  logic [CH-1:0] live;

  for (genvar n = 0; n < CH; n++) begin : g_chan
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst || !chan_en[n]) cnt <= '0;
      else if (cnt != CMAX)   cnt <= cnt + 1'b1;
    end
    assign qual[n] = (cnt == CMAX);
  end

  assign live = hot ? {CH{1'b1}} : (chan_en & qual & open_flag);

  always_ff @(posedge clk) begin
    if (rst)         status <= '0;
    else if (!blank) status <= live;
  end
endmodule

// File: rtl/led_onoff_core.sv
module led_onoff_core
  import led_core_pkg::*;
#(
  parameter int unsigned CH     = DEF_CH,
  parameter int unsigned STAGES = DEF_STAGES,
  parameter int unsigned MIN_ON = DEF_MIN_ON
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ser_clk_i,
  input  logic          ser_data_i,
  input  logic          ser_latch_i,
  input  logic          blank_i,
  input  logic [CH-1:0] open_flag_i,
  input  logic          hot_i,
  output logic          ser_data_o,
  output logic [CH-1:0] chan_en_o
);
  logic [2:0]    ctl_s;
  logic          blank_q;
  logic          sclk_d, lat_d;
  strobe_t       stb;
  logic          sin_q;
  logic [CH-1:0] shreg_q, onoff_q, stat_q;

  sync_chain #(.W(3), .STAGES(STAGES), .RST_VAL(1'b0)) u_ctl_sync (
    .clk(clk), .rst(rst),
    .d({ser_data_i, ser_latch_i, ser_clk_i}), .q(ctl_s)
  );

  sync_chain #(.W(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_blank_sync (
    .clk(clk), .rst(rst), .d(blank_i), .q(blank_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      lat_d  <= 1'b0;
    end else begin
      sclk_d <= ctl_s[0];
      lat_d  <= ctl_s[1];
    end
  end

  assign stb.sclk_rise = ctl_s[0] & ~sclk_d;
  assign stb.lat_rise  = ctl_s[1] & ~lat_d;
  assign sin_q         = ctl_s[2];

  onoff_shifter #(.CH(CH)) u_shift (
    .clk(clk), .rst(rst),
    .shift_en(stb.sclk_rise), .load_en(stb.lat_rise),
    .sin(sin_q), .status(stat_q),
    .shreg(shreg_q), .onoff(onoff_q)
  );

  fault_status #(.CH(CH), .MIN_ON(MIN_ON)) u_fault (
    .clk(clk), .rst(rst), .blank(blank_q),
    .chan_en(chan_en_o), .open_flag(open_flag_i), .hot(hot_i),
    .status(stat_q)
  );

  assign chan_en_o  = blank_q ? '0 : onoff_q;
  assign ser_data_o = shreg_q[CH-1];
endmodule

// File: rtl/led_onoff_core_chk.sv
module led_onoff_core_chk #(
  parameter int unsigned CH = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          sclk_rise,
  input logic          lat_rise,
  input logic          blank_q,
  input logic          sin_q,
  input logic          hot_i,
  input logic [CH-1:0] shreg_q,
  input logic [CH-1:0] onoff_q,
  input logic [CH-1:0] stat_q,
  input logic [CH-1:0] chan_en_o,
  input logic          ser_data_o
);
  assert_shift_R1: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !lat_rise) |=> shreg_q == {$past(shreg_q[CH-2:0]), $past(sin_q)});

  assert_sout_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (!sclk_rise && !lat_rise) |=> $stable(ser_data_o));

  assert_commit_R3: assert property (@(posedge clk) disable iff (rst)
    lat_rise |=> onoff_q == $past(shreg_q));

  assert_status_load_R4: assert property (@(posedge clk) disable iff (rst)
    (lat_rise && !sclk_rise) |=> shreg_q == $past(stat_q));

  assert_blank_off_R5: assert property (@(posedge clk) disable iff (rst)
    blank_q |-> chan_en_o == '0);

  assert_status_hold_R6: assert property (@(posedge clk) disable iff (rst)
    blank_q |=> $stable(stat_q));

  assert_hot_ones_R8: assert property (@(posedge clk) disable iff (rst)
    (hot_i && !blank_q) |=> stat_q == {CH{1'b1}});

  assert_load_then_shift_R10: assert property (@(posedge clk) disable iff (rst)
    (lat_rise && sclk_rise) |=> shreg_q == {$past(stat_q[CH-2:0]), $past(sin_q)});
endmodule

bind led_onoff_core led_onoff_core_chk #(.CH(CH)) u_chk (
  .clk(clk), .rst(rst),
  .sclk_rise(stb.sclk_rise), .lat_rise(stb.lat_rise),
  .blank_q(blank_q), .sin_q(sin_q), .hot_i(hot_i),
  .shreg_q(shreg_q), .onoff_q(onoff_q), .stat_q(stat_q),
  .chan_en_o(chan_en_o), .ser_data_o(ser_data_o)
);

// File: tb/led_onoff_core_test.sv
module led_onoff_core_test;
  localparam int CH     = 16;
  localparam int MIN_ON = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ser_clk_i = 1'b0, ser_data_i = 1'b0, ser_latch_i = 1'b0;
  logic          blank_i = 1'b1, hot_i = 1'b0;
  logic [CH-1:0] open_flag_i = '0;
  logic          ser_data_o;
  logic [CH-1:0] chan_en_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  led_onoff_core #(.CH(CH), .STAGES(2), .MIN_ON(MIN_ON)) uut (
    .clk(clk), .rst(rst), .ser_clk_i(ser_clk_i), .ser_data_i(ser_data_i),
    .ser_latch_i(ser_latch_i), .blank_i(blank_i), .open_flag_i(open_flag_i),
    .hot_i(hot_i), .ser_data_o(ser_data_o), .chan_en_o(chan_en_o)
  );

  task automatic check(string req, logic [CH-1:0] act, logic [CH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_pulse(logic b);
    ser_data_i = b; ser_clk_i = 1'b1; idle(4);
    ser_clk_i = 1'b0; idle(4);
  endtask

  task automatic lat_pulse();
    ser_latch_i = 1'b1; idle(4);
    ser_latch_i = 1'b0; idle(4);
  endtask

  // Shift in a word MSB first while collecting the old word from ser_data_o.
  task automatic xfer(input logic [CH-1:0] w, output logic [CH-1:0] old);
    for (int i = CH - 1; i >= 0; i--) begin
      old[i] = ser_data_o;
      sclk_pulse(w[i]);
    end
  endtask

  task automatic blank_window(int n);
    blank_i = 1'b0; idle(n);
    blank_i = 1'b1; idle(6);
  endtask

  task automatic t_reset();
    logic [CH-1:0] r;
    check("R11 enables after reset", chan_en_o, '0);
    check("R11 sout after reset", {15'd0, ser_data_o}, '0);
    xfer('0, r);
    check("R11 shift register after reset", r, '0);
  endtask

  task automatic t_shift();
    logic [CH-1:0] r;
    xfer(16'hA5C3, r);
    check("R2 sout shows bit 15", {15'd0, ser_data_o}, 16'd1);
    xfer('0, r);
    check("R1 shift order readback", r, 16'hA5C3);
  endtask

  task automatic t_commit_blank();
    logic [CH-1:0] r;
    xfer(16'h00F1, r);
    lat_pulse();
    check("R5 blank high forces off", chan_en_o, '0);
    open_flag_i = 16'h0211;
    blank_i = 1'b0; idle(20);
    check("R3 latch drives enables", chan_en_o, 16'h00F1);
    blank_i = 1'b1; idle(6);
    check("R5 enables off after blank rise", chan_en_o, '0);
    open_flag_i = '0; idle(4);
    xfer(16'h0F00, r);
    lat_pulse();
    xfer('0, r);
    check("R7 R6 R4 status readback masks disabled channel", r, 16'h0011);
  endtask

  task automatic t_qualify();
    logic [CH-1:0] r;
    xfer(16'h0F00, r);
    lat_pulse();
    open_flag_i = 16'h0100;
    blank_window(3);
    xfer('0, r);
    lat_pulse();
    xfer('0, r);
    check("R12 short enable window ignores flag", r, '0);
    xfer(16'h0F00, r);
    lat_pulse();
    blank_window(20);
    open_flag_i = '0;
    xfer('0, r);
    lat_pulse();
    xfer('0, r);
    check("R12 qualified channel reports flag", r, 16'h0100);
  endtask

  task automatic t_hot();
    logic [CH-1:0] r;
    hot_i = 1'b1;
    blank_window(5);
    hot_i = 1'b0; idle(4);
    lat_pulse();
    xfer('0, r);
    check("R8 over-temperature sets every bit", r, 16'hFFFF);
  endtask

  task automatic t_double_latch();
    logic [CH-1:0] r;
    xfer(16'h3C3C, r);
    lat_pulse();
    lat_pulse();
    blank_i = 1'b0; idle(6);
    check("R9 second strobe commits status word", chan_en_o, 16'hFFFF);
    open_flag_i = 16'h8421; idle(20);
    blank_i = 1'b1; idle(6);
    open_flag_i = '0; idle(4);
  endtask

  task automatic t_same_cycle();
    logic [CH-1:0] r;
    xfer(16'h1234, r);
    ser_data_i = 1'b1; ser_clk_i = 1'b1; ser_latch_i = 1'b1; idle(4);
    ser_clk_i = 1'b0; ser_latch_i = 1'b0; idle(4);
    xfer('0, r);
    check("R10 load then shift in same clock", r, 16'h0843);
    blank_i = 1'b0; idle(6);
    check("R10 latch took pre-shift word", chan_en_o, 16'h1234);
    blank_i = 1'b1; idle(6);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(4);
    t_reset();
    t_shift();
    t_commit_blank();
    t_qualify();
    t_hot();
    t_double_latch();
    t_same_cycle();
    finish_run();
  end
endmodule